// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank with Deferred Ratio Update

This block holds a small bank of integer dividers. Each one turns the core clock into a one-cycle enable pulse that repeats at a programmable ratio. A divider's ratio is chosen by a short code. A four-entry table, fixed by a parameter, maps each code to a division ratio. All codes share one 32-bit control word on a simple memory-mapped bus. Each field has its own write-enable bit in the upper half of that word, so software can change one divider without a read-modify-write of the others.

A write does not change the ratio at once. The divider raises a busy bit in a separate status word. It keeps its current ratio until the period in progress has finished, then switches to the new ratio and drops busy. Software is expected to see busy low before it writes and to poll until busy is low again after the write. The block rejects any write to a divider whose busy bit is set.

Top module: `ddiv_bank`

## Requirements
- R1: After reset, divider 0 holds code 2 (ratio 4), divider 1 holds code 1 (ratio 2), and both busy bits are 0.
- R2: A read of the control word (address 0x200) returns divider i's code in bits [4i+1:4i], and every other bit reads 0.
- R3: A bus write to 0x200 with bit 4i+16 set, while divider i is idle, stores bits [4i+1:4i] as the new code, and busy i reads 1 from the next cycle on.
- R4: A write to 0x200 with bit 4i+16 clear leaves divider i's code, busy bit and output period unchanged.
- R5: A write to divider i while its busy bit is 1 is ignored: the code stays, and the pending update completes with the value written earlier.
- R6: A read of the status word (address 0x700) returns busy of divider i in bit i, and every other bit reads 0.
- R7: Codes 0, 1, 2 and 3 select ratios 1, 2, 4 and 8. The enable output of a divider with ratio N is high for one cycle in every N cycles.
- R8: With ratio 1, the enable output is high on every cycle.
- R9: A new ratio takes effect only after the period in progress has run its full old length. Busy is still 1 in the cycle of that period's last pulse and reads 0 in the next cycle, which is the first cycle under the new ratio.
- R10: Writing one divider leaves the other divider's code and period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| div_en | output | 2 | One enable pulse per divider |

## Verification
Read data is combinational, so the bench samples it one time step after it drives the address. A write is captured on the rising edge that follows its drive. Busy is therefore checked at the falling edge after that rising edge. Enable periods are measured from one falling-edge sample showing a pulse to the next one.

The check for a deferred update (R9) starts the write at the falling edge of an old-ratio pulse. At that point a full old period of 8 cycles is due before the next pulse. The bench checks that busy is still 1 in that pulse and reads 0 one cycle later, when the ratio-1 output is already high. Every wait for busy is bounded by a cycle count, so a divider that never applies its update fails a check instead of stalling the run.

// File: rtl/ddiv_pkg.sv
package ddiv_pkg;
    localparam int BUS_DW        = 32;
    localparam int FIELD_SPAN    = 16;              // fields live in the low half
    localparam int WE_OFFSET     = FIELD_SPAN;      // write enable sits one half above its field
    localparam logic [11:0] CTRL_ADDR = 12'h200;
    localparam logic [11:0] STAT_ADDR = 12'h700;
endpackage

// File: rtl/ddiv_regif.sv
module ddiv_regif
    import ddiv_pkg::*;
#(
    parameter int NUM_DIV = 2,
    parameter int CODE_W  = 2,
    parameter int STRIDE  = 4,
    parameter int ADDR_W  = 12
) (
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BUS_DW-1:0]         bus_wdata,
    input  logic [NUM_DIV*CODE_W-1:0] codes,
    input  logic [NUM_DIV-1:0]        busy,
    output logic [NUM_DIV-1:0]        wr_hit,
    output logic [NUM_DIV*CODE_W-1:0] wr_code,
    output logic [BUS_DW-1:0]         bus_rdata
);
    logic ctrl_sel;
    logic stat_sel;
    logic unused_wdata;

    assign ctrl_sel     = (bus_addr == CTRL_ADDR[ADDR_W-1:0]);
    assign stat_sel     = (bus_addr == STAT_ADDR[ADDR_W-1:0]);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        wr_hit    = '0;
        wr_code   = '0;
        bus_rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            wr_hit[i] = bus_wr && ctrl_sel && bus_wdata[WE_OFFSET + i*STRIDE];
            wr_code[i*CODE_W +: CODE_W] = bus_wdata[i*STRIDE +: CODE_W];
            if (ctrl_sel) begin
                bus_rdata[i*STRIDE +: CODE_W] = codes[i*CODE_W +: CODE_W];
            end
            if (stat_sel) begin
                bus_rdata[i] = busy[i];
            end
        end
    end
endmodule

// File: rtl/ddiv_lane.sv
module ddiv_lane #(
    parameter int                          CODE_W     = 2,
    parameter int                          RATIO_W    = 4,
    parameter logic [(2**CODE_W)*RATIO_W-1:0] RATIO_TAB  = '0,
    parameter logic [CODE_W-1:0]           RESET_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o,
    output logic              tick_o
);
    typedef struct packed {
        logic [CODE_W-1:0]  code;   // last accepted code
        logic [CODE_W-1:0]  act;    // code in force
        logic [RATIO_W-1:0] cnt;
        logic               busy;
    } lane_t;

    lane_t s_q, s_d;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] last;
    logic               wrap;

    always_comb begin
        ratio = RATIO_TAB[int'(s_q.act)*RATIO_W +: RATIO_W];
        last  = (ratio == '0) ? '0 : ratio - 1'b1;
        wrap  = (s_q.cnt == last);

        s_d     = s_q;
        s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        if (s_q.busy && wrap) begin
            s_d.act  = s_q.code;
            s_d.busy = 1'b0;
        end
        if (wr_hit && !s_q.busy) begin
            s_d.code = wr_code;
            s_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.code <= RESET_CODE;
            s_q.act  <= RESET_CODE;
            s_q.cnt  <= '0;
            s_q.busy <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o = s_q.code;
    assign busy_o = s_q.busy;
    assign tick_o = wrap;
endmodule

// File: rtl/ddiv_bank.sv
module ddiv_bank
    import ddiv_pkg::*;
#(
    parameter int NUM_DIV = 2,
    parameter int CODE_W  = 2,
    parameter int STRIDE  = 4,
    parameter int RATIO_W = 4,
    parameter int ADDR_W  = 12,
    parameter logic [(2**CODE_W)*RATIO_W-1:0] RATIO_TAB = {4'd8, 4'd4, 4'd2, 4'd1},
    parameter logic [NUM_DIV*CODE_W-1:0] RESET_CODES = {2'd1, 2'd2}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_DIV-1:0] div_en
);
    localparam int CODES_W = NUM_DIV * CODE_W;

    logic [CODES_W-1:0] code_vec;
    logic [CODES_W-1:0] wr_code_vec;
    logic [NUM_DIV-1:0] wr_hit_vec;
    logic [NUM_DIV-1:0] busy_vec;

    ddiv_regif #(
        .NUM_DIV(NUM_DIV), .CODE_W(CODE_W), .STRIDE(STRIDE), .ADDR_W(ADDR_W)
    ) u_regif (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .codes     (code_vec),
        .busy      (busy_vec),
        .wr_hit    (wr_hit_vec),
        .wr_code   (wr_code_vec),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_lane
        ddiv_lane #(
            .CODE_W    (CODE_W),
            .RATIO_W   (RATIO_W),
            .RATIO_TAB (RATIO_TAB),
            .RESET_CODE(RESET_CODES[g*CODE_W +: CODE_W])
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit_vec[g]),
            .wr_code (wr_code_vec[g*CODE_W +: CODE_W]),
            .code_o  (code_vec[g*CODE_W +: CODE_W]),
            .busy_o  (busy_vec[g]),
            .tick_o  (div_en[g])
        );
    end
endmodule

// File: rtl/ddiv_bank_chk.sv
module ddiv_bank_chk
    import ddiv_pkg::*;
#(
    parameter int NUM_DIV = 2,
    parameter int STRIDE  = 4,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NUM_DIV-1:0] busy,
    input logic [NUM_DIV-1:0] div_en
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR[ADDR_W-1:0]);

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_prop
        // R3: an accepted write raises busy
        p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_wr && bus_wdata[WE_OFFSET + g*STRIDE] && !busy[g] |=> busy[g]);
        // R4: without its enable bit the field stays idle
        p_no_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_wr && !bus_wdata[WE_OFFSET + g*STRIDE] && !busy[g] |=> !busy[g]);
        // R5: busy is only released at a period boundary
        p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            busy[g] && !div_en[g] |=> busy[g]);
        // R9: a pending update is applied at the first boundary
        p_apply_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            busy[g] && div_en[g] |=> !busy[g]);
    end
endmodule

bind ddiv_bank ddiv_bank_chk #(
    .NUM_DIV(NUM_DIV), .STRIDE(STRIDE), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy_vec),
    .div_en    (div_en)
);

// File: tb/ddiv_bank_tb.sv
module ddiv_bank_tb;
    localparam logic [11:0] CTRL = 12'h200;
    localparam logic [11:0] STAT = 12'h700;
    localparam int NV = 5;
    localparam int VEC_CODE [NV]  = '{3, 0, 1, 2, 3};
    localparam int VEC_RATIO[NV]  = '{8, 1, 2, 4, 8};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  div_en;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ddiv_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_en(div_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus_write(input logic [31:0] d);
        bus_addr  = CTRL;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_idle(input int idx, output int ok);
        int v;
        ok = 0;
        for (int k = 0; k < 40; k++) begin
            bus_read(STAT, v);
            if (v[idx] == 1'b0) begin
                ok = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic measure(input int idx, output int n);
        n = -1;
        for (int k = 0; k < 40; k++) begin
            if (div_en[idx]) break;
            @(negedge clk);
        end
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (div_en[idx]) begin
                n = k;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, ok, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R2: reset state through the bus
        bus_read(CTRL, v); chk("R1 ctrl word", v, 32'h12);
        bus_read(STAT, v); chk("R1 status", v, 0);
        measure(0, n);     chk("R1 div0 period", n, 4);
        measure(1, n);     chk("R1 div1 period", n, 2);

        // vector table: code -> ratio on divider 0 (R3 R2 R7)
        for (int t = 0; t < NV; t++) begin
            @(negedge clk);
            wait_idle(0, ok);
            bus_write(32'h0001_0000 | 32'(VEC_CODE[t]));
            bus_read(STAT, v);  chk("R3 busy after write", v & 1, 1);
            wait_idle(0, ok);   chk("R3 busy clears", ok, 1);
            bus_read(CTRL, v);  chk("R2 field readback", v & 3, VEC_CODE[t]);
            measure(0, n);      chk("R7 period", n, VEC_RATIO[t]);
            measure(0, n);      chk("R7 period repeat", n, VEC_RATIO[t]);
        end

        // R4: enable bit clear, divider 0 currently code 3
        @(negedge clk);
        bus_write(32'h0000_0001);
        bus_read(STAT, v);  chk("R4 busy stays 0", v, 0);
        bus_read(CTRL, v);  chk("R4 code unchanged", v & 3, 3);
        measure(0, n);      chk("R4 period unchanged", n, 8);

        // R9: deferred apply 8 -> 1 started at an old pulse
        for (int k = 0; k < 20; k++) begin
            if (div_en[0]) break;
            @(negedge clk);
        end
        bus_write(32'h0001_0000);  // now one cycle into the old period
        n = 1;
        for (int k = 0; k < 20; k++) begin
            if (div_en[0]) break;
            @(negedge clk);
            n++;
        end
        chk("R9 full old period", n, 8);
        bus_read(STAT, v);  chk("R9 busy at last old pulse", v & 1, 1);
        @(negedge clk);
        bus_read(STAT, v);  chk("R9 busy cleared next cycle", v & 1, 0);
        chk("R9 new ratio pulse", int'(div_en[0]), 1);

        // R8: ratio 1 steady high
        v = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!div_en[0]) v = 0;
        end
        chk("R8 always high", v, 1);

        // R5: second write while busy is ignored
        bus_write(32'h0001_0003);
        bus_write(32'h0001_0001);
        wait_idle(0, ok);
        bus_read(CTRL, v);  chk("R5 code kept", v & 3, 3);
        measure(0, n);      chk("R5 period from first write", n, 8);

        // R6 and R10: divider 1 busy alone, divider 0 untouched
        @(negedge clk);
        bus_write(32'h0010_0030);
        bus_read(STAT, v);  chk("R6 status bit1 only", v, 2);
        wait_idle(1, ok);
        bus_read(CTRL, v);  chk("R10 ctrl both fields", v, 32'h33);
        measure(0, n);      chk("R10 div0 period kept", n, 8);
        measure(1, n);      chk("R7 div1 period", n, 8);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule